// File: doc/BRIEF.md
# Model-Cycle Barrier Controller

This block keeps a set of simulation modules in lockstep on simulated (model) clock cycles. It holds a counter of the current model cycle and sends a one-cycle start pulse to every module. It then collects a completion indication from each module. Only when every module has finished does the counter advance and the next model cycle start.

A model cycle therefore lasts a variable number of hardware clock cycles. The slowest module in each model cycle sets that length. A run input gates the start of new model cycles. When run is dropped, the model cycle already under way still finishes, but no further start pulse is sent.

Top module: `barrier_sync_ctrl`

## Requirements
- R1: After synchronous reset, `model_cycle` is 0, every bit of `begin_o` is 0 and the controller is idle.
- R2: When the controller is idle and `run_en` is sampled high, `begin_o` goes high on all NUM_MODS bits at once for exactly one clock, in the cycle after `run_en` was sampled.
- R3: A high `done_i[k]` seen in any cycle of an active model cycle, including the cycle in which `begin_o` is high, stays recorded until that model cycle completes, even if `done_i[k]` falls again.
- R4: In the cycle where every module is recorded (or currently shows) done, the model cycle completes. `model_cycle` then reads one more in the next clock, and if `run_en` was high in the completing cycle, `begin_o` pulses in that same next clock.
- R5: A model cycle never completes while any module has not reported done, so its length follows the slowest module.
- R6: `done_i` is ignored while the controller is idle, and records from a finished model cycle are cleared, so a new model cycle needs a fresh done from every module.
- R7: If `run_en` is low in the cycle a model cycle completes, the counter still advances but no `begin_o` pulse follows. The controller stays idle until `run_en` is seen high, and then it pulses `begin_o` in the next clock.
- R8: `model_cycle` counts modulo 2^CNT_W, so it steps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hardware clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Permits new model cycles to start |
| done_i | input | NUM_MODS | Completion indication, one bit per module |
| begin_o | output | NUM_MODS | Start pulse, one bit per module, all bits equal |
| model_cycle | output | CNT_W | Current model cycle count |

## Verification
The controller is driven with directed completion orders and with random completion patterns. In the directed orders, modules finish one at a time, an early finisher drops its done line, and the slowest module finishes last. These separate correct sticky latching from completion on whatever happens to be high at once. Done pulses while idle, and done lines left high across a model-cycle boundary, show whether stale completions are wrongly counted. Dropping run mid-cycle and running back-to-back one-cycle model cycles past the counter limit test the stop rule and the wrap. Long random stretches, with run mostly held high, are then compared each clock against a reference model in the bench.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    // Control strobes passed from the sequencer to the datapath pieces
    typedef struct packed {
        logic start;    // issue a begin pulse next clock
        logic retire;   // current model cycle completes this clock
        logic capture;  // done inputs are being collected
    } bar_ctl_t;

endpackage

// File: rtl/done_collector.sv
module done_collector #(
    parameter int NUM_MODS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                capture,
    input  logic [NUM_MODS-1:0] done_i,
    output logic                all_done
);
    logic [NUM_MODS-1:0] flag_q;
    logic [NUM_MODS-1:0] seen;

    for (genvar g = 0; g < NUM_MODS; g++) begin : g_mod
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                flag_q[g] <= 1'b0;
            end else if (capture && done_i[g]) begin
                flag_q[g] <= 1'b1;
            end
        end
        assign seen[g] = flag_q[g] | (capture & done_i[g]);
    end

    assign all_done = capture & (&seen);

endmodule

// File: rtl/model_cycle_counter.sv
module model_cycle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             incr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (incr) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/barrier_seq.sv
module barrier_seq
    import barrier_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_en,
    input  logic     all_done,
    output bar_ctl_t ctl,
    output logic     begin_pulse
);
    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        ctl.capture = (phase_q == PH_WAIT);
        ctl.retire  = ctl.capture && all_done;
        ctl.start   = run_en && ((phase_q == PH_IDLE) || ctl.retire);
        phase_d     = phase_q;
        if (ctl.start) begin
            phase_d = PH_WAIT;
        end else if (ctl.retire) begin
            phase_d = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            begin_pulse <= 1'b0;
        end else begin
            phase_q     <= phase_d;
            begin_pulse <= ctl.start;
        end
    end

endmodule

// File: rtl/barrier_sync_ctrl.sv
module barrier_sync_ctrl
    import barrier_pkg::*;
#(
    parameter int NUM_MODS = 4,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic [NUM_MODS-1:0] done_i,
    output logic [NUM_MODS-1:0] begin_o,
    output logic [CNT_W-1:0]    model_cycle
);
    bar_ctl_t ctl;
    logic     all_done;
    logic     begin_pulse;

    barrier_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .all_done   (all_done),
        .ctl        (ctl),
        .begin_pulse(begin_pulse)
    );

    done_collector #(.NUM_MODS(NUM_MODS)) u_coll (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctl.retire),
        .capture (ctl.capture),
        .done_i  (done_i),
        .all_done(all_done)
    );

    model_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .incr (ctl.retire),
        .count(model_cycle)
    );

    for (genvar g = 0; g < NUM_MODS; g++) begin : g_fan
        assign begin_o[g] = begin_pulse;
    end

endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
    parameter int NUM_MODS = 4,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                run_en,
    input logic [NUM_MODS-1:0] done_i,
    input logic [NUM_MODS-1:0] begin_o,
    input logic [CNT_W-1:0]    model_cycle
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (model_cycle == '0) && (begin_o == '0));

    // R2
    begin_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (begin_o == '0) || (begin_o == '1));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && (model_cycle != $past(model_cycle))
            |-> model_cycle == $past(model_cycle) + ONE);

    // R7
    run_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> begin_o == '0);

    // R6
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && (model_cycle != $past(model_cycle)) && (begin_o == '0)
            |=> $stable(model_cycle) || (begin_o != '0) || $past(begin_o != '0));

endmodule

bind barrier_sync_ctrl barrier_sync_chk #(
    .NUM_MODS(NUM_MODS),
    .CNT_W   (CNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .done_i     (done_i),
    .begin_o    (begin_o),
    .model_cycle(model_cycle)
);

// File: tb/barrier_sync_ctrl_tb_top.sv
module barrier_sync_ctrl_tb_top;
    localparam int N       = 4;
    localparam int W       = 4;
    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic [N-1:0] done_i = '0;
    logic [N-1:0] begin_o;
    logic [W-1:0] model_cycle;

    int n_checks = 0;
    int n_errs   = 0;
    int cyc      = 0;

    // reference model state
    bit           m_wait  = 1'b0;
    bit [N-1:0]   m_flags = '0;
    bit [W-1:0]   m_cnt   = '0;
    bit           m_beg   = 1'b0;

    barrier_sync_ctrl #(.NUM_MODS(N), .CNT_W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .done_i     (done_i),
        .begin_o    (begin_o),
        .model_cycle(model_cycle)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic void finish_run();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            finish_run();
        end
    end

    function automatic void check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    function automatic bit [N-1:0] beg_exp();
        return m_beg ? '1 : '0;
    endfunction

    // one clock: drive at negedge, advance model at posedge, check at next negedge
    task automatic step(input bit run, input bit [N-1:0] d, input string req);
        bit all_d;
        bit start;
        run_en = run;
        done_i = d;
        all_d  = m_wait && ((m_flags | d) == '1);
        start  = run && (!m_wait || all_d);
        @(posedge clk);
        m_beg = start;
        if (all_d) m_cnt = m_cnt + 1'b1;
        if (all_d || start) m_flags = '0;
        else if (m_wait) m_flags = m_flags | d;
        if (start) m_wait = 1'b1;
        else if (all_d) m_wait = 1'b0;
        @(negedge clk);
        check(req, "begin_o", int'(begin_o), int'(beg_exp()));
        check(req, "model_cycle", int'(model_cycle), int'(m_cnt));
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "model_cycle", int'(model_cycle), 0);
        check("R1", "begin_o", int'(begin_o), 0);

        // R6: done while idle is ignored
        repeat (3) step(1'b0, '1, "R6");
        check("R6", "idle count", int'(model_cycle), 0);

        // R2: start pulse
        step(1'b1, 4'b0000, "R2");
        check("R2", "begin all bits", int'(begin_o), 15);
        step(1'b1, 4'b0000, "R2");
        check("R2", "single pulse", int'(begin_o), 0);

        // R3 / R5: staggered finishes, early one drops, slowest last
        step(1'b1, 4'b0001, "R3");
        step(1'b1, 4'b0000, "R3");
        step(1'b1, 4'b0100, "R3");
        step(1'b1, 4'b0010, "R5");
        check("R5", "not yet complete", int'(model_cycle), 0);
        step(1'b1, 4'b1000, "R4");
        check("R4", "count after barrier", int'(model_cycle), 1);
        check("R4", "next begin", int'(begin_o), 15);

        // R6: stale records cleared; three done, one missing
        step(1'b1, 4'b0111, "R6");
        step(1'b1, 4'b0111, "R6");
        check("R6", "waits for module 3", int'(model_cycle), 1);

        // R7: run dropped, current cycle still completes
        step(1'b0, 4'b1000, "R7");
        check("R7", "counts", int'(model_cycle), 2);
        check("R7", "no begin", int'(begin_o), 0);
        repeat (3) step(1'b0, '1, "R7");
        check("R7", "stays idle", int'(model_cycle), 2);
        step(1'b1, 4'b0000, "R7");
        check("R7", "resume begin", int'(begin_o), 15);

        // R8: back-to-back one-clock model cycles across the wrap
        for (int i = 0; i < 20; i++) step(1'b1, '1, "R8");
        check("R8", "wrapped value", int'(model_cycle), int'(m_cnt));

        // R4: random completion patterns
        for (int i = 0; i < 4000; i++) begin
            bit [N-1:0] d;
            for (int k = 0; k < N; k++) d[k] = ($urandom_range(0, 99) < 35);
            step($urandom_range(0, 99) < 90, d, "R4");
        end

        finish_run();
    end

endmodule